// File: doc/BRIEF.md
# Glitchless Serpentine Thermometer Decoder

The decoder turns a binary control word into on/off enables for a square array of unit cells. Under default parameters, a 10-bit word drives 1024 cells laid out as 32 rows by 32 columns. The number of enabled cells always equals the code, so the array behaves as a monotonic unit-element converter. Each row takes the upper part of the code and each column takes the lower part. A cell resolves its own state from the row lines next to it and one shared column line.

Rows fill in serpentine order. Even rows fill from column 0 upward, and a cell in an even row is on when its column line is high. Odd rows fill from the top column downward, and a cell in an odd row is on when its column line is low. The column lines are therefore driven from the true column part in even rows and from its complement in odd rows.

With this ordering, a one-LSB step changes the state of exactly one cell, including the steps that cross a row boundary. Skew between the row and column paths therefore cannot cause a transient extra cell to switch. The input word is registered, and so are all three output groups, so the row code, column code and cell enables change together on one clock edge.

Top module: `tdec_top`

## Requirements
- R1: While rst_ni is low, and after it is released until a code is captured, row_therm_o, col_therm_o and cell_en_o are all zero.
- R2: code_i is captured on one rising edge. The outputs for that code appear together on the next rising edge (two edges from the drive), and the outputs do not change after only the first edge.
- R3: Row code: with row = code[9:5], row_therm_o[r] is 1 exactly when r < row.
- R4: Column code in an even active row (code[5] = 0): with col = code[4:0], col_therm_o[j] is 1 exactly when j < col.
- R5: Column code in an odd active row (code[5] = 1): col_therm_o[j] is 1 exactly when j <= 31 - col.
- R6: Cell enable cell_en_o[r*32+j] is 1 when r < row. When r == row, it is 1 for an even r if col_therm_o[j] is 1, and for an odd r if col_therm_o[j] is 0. In every other case it is 0.
- R7: The number of set bits in cell_en_o equals the code. Code 0 enables no cell, and code 1023 enables every cell except index 992 (row 31, column 0).
- R8: When the code rises by one, including across row boundaries, exactly one cell changes, and that cell turns on. When the code rises, no cell turns off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| code_i | input | 10 | Binary control word |
| row_therm_o | output | 32 | Fully-on row thermometer |
| col_therm_o | output | 32 | Shared column thermometer (serpentine) |
| cell_en_o | output | 1024 | Resolved per-cell enables, index row*32+column |

## Verification
On every cycle, the assertions check the following against the captured code:
- the on-cell count of cell_en_o;
- the row count and the parity-dependent column count;
- the one-cell, turn-on-only change for each unit step;
- that no cell turns off when the code rises.

Only the bench scenarios can show the exact bit positions: which side of an odd row fills, and which single cell stays off at full scale. They also show the two-edge latency and the reset state. The bench covers these with a full ascending sweep, random codes and directed row-boundary cases.

// File: rtl/tdec_pkg.sv
package tdec_pkg;
  localparam int unsigned DEF_ROW_W = 5;
  localparam int unsigned DEF_COL_W = 5;
endpackage

// File: rtl/tdec_therm.sv
// Binary to thermometer; INCL selects j <= val instead of j < val.
module tdec_therm #(
  parameter int unsigned W    = 5,
  parameter bit          INCL = 1'b0,
  localparam int unsigned N   = 1 << W
) (
  input  logic [W-1:0] val_i,
  output logic [N-1:0] therm_o
);
  for (genvar j = 0; j < N; j++) begin : g_bit
    localparam logic [W:0] JV = (W+1)'(j);
    if (INCL) begin : g_incl
      assign therm_o[j] = (JV <= {1'b0, val_i});
    end else begin : g_excl
      assign therm_o[j] = (JV < {1'b0, val_i});
    end
  end
endmodule

// File: rtl/tdec_col_sel.sv
// Serpentine column drive: true part in even rows, complement in odd rows.
module tdec_col_sel #(
  parameter int unsigned COL_W = 5,
  localparam int unsigned NUM_COLS = 1 << COL_W
) (
  input  logic [COL_W-1:0]    col_i,
  input  logic                row_odd_i,
  output logic [NUM_COLS-1:0] col_therm_o
);
  logic [NUM_COLS-1:0] even_therm, odd_therm;

  tdec_therm #(.W(COL_W), .INCL(1'b0)) u_even (.val_i(col_i),  .therm_o(even_therm));
  tdec_therm #(.W(COL_W), .INCL(1'b1)) u_odd  (.val_i(~col_i), .therm_o(odd_therm));

  assign col_therm_o = row_odd_i ? odd_therm : even_therm;
endmodule

// File: rtl/tdec_cell_array.sv
module tdec_cell_array #(
  parameter int unsigned NUM_ROWS = 32,
  parameter int unsigned NUM_COLS = 32,
  localparam int unsigned NUM_CELLS = NUM_ROWS * NUM_COLS
) (
  input  logic [NUM_ROWS-1:0]  row_full_i,
  input  logic [NUM_ROWS-1:0]  row_upto_i,
  input  logic [NUM_COLS-1:0]  col_therm_i,
  output logic [NUM_CELLS-1:0] cell_en_o
);
  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    for (genvar j = 0; j < NUM_COLS; j++) begin : g_col
      if (r % 2 == 0) begin : g_even
        assign cell_en_o[r*NUM_COLS+j] = row_full_i[r] | (row_upto_i[r] & col_therm_i[j]);
      end else begin : g_odd
        assign cell_en_o[r*NUM_COLS+j] = row_full_i[r] | (row_upto_i[r] & ~col_therm_i[j]);
      end
    end
  end
endmodule

// File: rtl/tdec_top.sv
module tdec_top
  import tdec_pkg::*;
#(
  parameter int unsigned ROW_W = DEF_ROW_W,
  parameter int unsigned COL_W = DEF_COL_W,
  localparam int unsigned CODE_W    = ROW_W + COL_W,
  localparam int unsigned NUM_ROWS  = 1 << ROW_W,
  localparam int unsigned NUM_COLS  = 1 << COL_W,
  localparam int unsigned NUM_CELLS = NUM_ROWS * NUM_COLS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CODE_W-1:0]    code_i,
  output logic [NUM_ROWS-1:0]  row_therm_o,
  output logic [NUM_COLS-1:0]  col_therm_o,
  output logic [NUM_CELLS-1:0] cell_en_o
);
  logic [CODE_W-1:0]    code_q;
  logic [ROW_W-1:0]     row_sel;
  logic [COL_W-1:0]     col_sel;
  logic [NUM_ROWS-1:0]  row_full, row_upto;
  logic [NUM_COLS-1:0]  col_therm;
  logic [NUM_CELLS-1:0] cell_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else         code_q <= code_i;
  end

  assign row_sel = code_q[COL_W +: ROW_W];
  assign col_sel = code_q[COL_W-1:0];

  tdec_therm #(.W(ROW_W), .INCL(1'b0)) u_row_full (.val_i(row_sel), .therm_o(row_full));
  tdec_therm #(.W(ROW_W), .INCL(1'b1)) u_row_upto (.val_i(row_sel), .therm_o(row_upto));

  tdec_col_sel #(.COL_W(COL_W)) u_col (
    .col_i      (col_sel),
    .row_odd_i  (row_sel[0]),
    .col_therm_o(col_therm)
  );

  tdec_cell_array #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) u_cells (
    .row_full_i (row_full),
    .row_upto_i (row_upto),
    .col_therm_i(col_therm),
    .cell_en_o  (cell_en)
  );

  // All three groups launch from one register stage.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_therm_o <= '0;
      col_therm_o <= '0;
      cell_en_o   <= '0;
    end else begin
      row_therm_o <= row_full;
      col_therm_o <= col_therm;
      cell_en_o   <= cell_en;
    end
  end

  AST_CELL_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($countones(cell_en_o) == int'($past(code_q)))); // R7

  AST_ROW_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($countones(row_therm_o) == int'($past(code_q[COL_W +: ROW_W])))); // R3

  AST_COL_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !code_q[COL_W] |=> ($countones(col_therm_o) == int'($past(code_q[COL_W-1:0])))); // R4

  AST_COL_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_q[COL_W] |=> ($countones(col_therm_o) == int'(NUM_COLS) - int'($past(code_q[COL_W-1:0])))); // R5

  AST_UNIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, code_q} == {1'b0, $past(code_q)} + (CODE_W+1)'(1))
    |=> ($countones(cell_en_o ^ $past(cell_en_o)) == 1)); // R8

  AST_NO_TURN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q > $past(code_q)) |=> (($past(cell_en_o) & ~cell_en_o) == '0)); // R8
endmodule

// File: tb/tdec_top_tb_top.sv
module tdec_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS  = 32;
  localparam int COLS  = 32;
  localparam int CELLS = ROWS * COLS;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [9:0]       code = '0;
  logic [ROWS-1:0]  row_therm;
  logic [COLS-1:0]  col_therm;
  logic [CELLS-1:0] cell_en;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdec_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .code_i(code),
    .row_therm_o(row_therm), .col_therm_o(col_therm), .cell_en_o(cell_en)
  );

  function automatic logic [ROWS-1:0] exp_row(int c);
    logic [ROWS-1:0] v = '0;
    for (int r = 0; r < ROWS; r++) v[r] = (r < c / COLS);
    return v;
  endfunction

  function automatic logic [COLS-1:0] exp_col(int c);
    logic [COLS-1:0] v = '0;
    int cp = c % COLS;
    bit odd = ((c / COLS) % 2) == 1;
    for (int j = 0; j < COLS; j++) v[j] = odd ? (j <= COLS - 1 - cp) : (j < cp);
    return v;
  endfunction

  function automatic logic [CELLS-1:0] exp_cells(int c);
    logic [CELLS-1:0] v = '0;
    logic [COLS-1:0] cl = exp_col(c);
    int row = c / COLS;
    for (int r = 0; r < ROWS; r++)
      for (int j = 0; j < COLS; j++)
        v[r*COLS+j] = (r < row) || (r == row && ((r % 2 == 0) ? cl[j] : !cl[j]));
    return v;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(int c);
    chk(row_therm == exp_row(c), "R3 row", longint'(row_therm), longint'(exp_row(c)));
    chk(col_therm == exp_col(c), (((c / COLS) % 2) == 1) ? "R5 col odd" : "R4 col even",
        longint'(col_therm), longint'(exp_col(c)));
    chk(cell_en == exp_cells(c), "R6 cells (count shown)",
        longint'($countones(cell_en)), longint'($countones(exp_cells(c))));
    chk($countones(cell_en) == c, "R7 count", longint'($countones(cell_en)), longint'(c));
  endtask

  // Drive at negedge, capture edge, output edge, sample at negedge.
  task automatic apply(int c);
    code = 10'(c);
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  initial begin
    logic [CELLS-1:0] prev;
    code = 10'd700;
    repeat (3) @(negedge clk);
    chk(row_therm == '0 && col_therm == '0 && cell_en == '0, "R1 in reset",
        longint'($countones(cell_en)), 0);
    rst_n = 1'b1;
    @(negedge clk);
    code = 10'd0;
    chk(cell_en == '0 && row_therm == '0, "R1 after release", longint'($countones(cell_en)), 0);

    apply(0);
    check_all(0);

    // R2: one edge is not enough, two edges update all groups together.
    code = 10'd131;
    @(posedge clk); @(negedge clk);
    chk(cell_en == '0 && row_therm == '0 && col_therm == '0, "R2 no early change",
        longint'($countones(cell_en)), 0);
    @(posedge clk); @(negedge clk);
    chk(row_therm == exp_row(131) && col_therm == exp_col(131) && cell_en == exp_cells(131),
        "R2 groups aligned", longint'($countones(cell_en)), 131);

    // R7 full scale: only cell 992 off.
    apply(1023);
    check_all(1023);
    chk(cell_en[992] == 1'b0 && $countones(cell_en) == CELLS - 1, "R7 full scale",
        longint'(cell_en[992]), 0);

    // R5 odd row fills from top column.
    apply(33);
    chk(cell_en[63] == 1'b1 && cell_en[32] == 1'b0, "R5 odd row side",
        longint'(cell_en[63:32]), longint'(exp_cells(33) >> 32));

    // R8 full ascending sweep.
    apply(0);
    prev = cell_en;
    for (int c = 1; c < 1024; c++) begin
      apply(c);
      check_all(c);
      chk($countones(prev ^ cell_en) == 1 && (prev & ~cell_en) == '0, "R8 unit step",
          longint'($countones(prev ^ cell_en)), 1);
      prev = cell_en;
    end

    // Random codes with a fixed seed.
    void'($urandom(32'd1234));
    for (int i = 0; i < 300; i++) begin
      int c = int'($urandom_range(1023, 0));
      apply(c);
      check_all(c);
      if (c > 0) begin
        prev = cell_en;
        apply(c - 1);
        chk((cell_en & ~prev) == '0 && $countones(prev ^ cell_en) == 1, "R8 step down",
            longint'($countones(prev ^ cell_en)), 1);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule